// File: doc/BRIEF.md
# PIO Cycle Timing Generator

This block times one programmed-I/O or register-access cycle on a parallel ATA bus. A cycle runs through four phases in a fixed order: address and chip-select setup, the read or write strobe, data hold, and recovery before the next cycle. Each phase length comes from an 8-bit field of a packed 32-bit timing word. Each field holds the wanted number of clocks minus one.

Each device has two timing words, one for register (command) cycles and one for data cycles, so four words are supplied in all. When a start request arrives, the block takes a snapshot of the chosen word, the direction, the address and the chip-select. It then drives the strobes and, for writes, the data bus, and raises `done` for one clock at the end. Each device has its own enable. When that enable is set, the device's IORDY line can hold the strobe open past its programmed width.

Top module: `pio_cycle_timer`

## Requirements
- R1: A timing word holds setup in bits [7:0], strobe width in [15:8], hold in [23:16] and recovery in [31:24]. A field value of n makes its phase last n+1 clocks. Setup lasts from the first clock after the start is accepted until the strobe begins.
- R2: The strobe lasts strobe+1 clocks when no wait is applied. Hold follows for hold+1 clocks, then recovery for recovery+1 clocks. `busy` stays high for the sum of all four phase lengths. `done` is high for exactly one clock, the clock after the last recovery clock.
- R3: The word is chosen by `dev` (0 or 1) and `data_cyc`: 0 selects a register cycle and 1 a data cycle. The four choices map to `t_cmd0`, `t_dat0`, `t_cmd1` and `t_dat1`.
- R4: A read (`wr`=0) drives `dior_n` low during the strobe phase only. `rdata` captures `dd_in` on the clock edge at which `dior_n` returns high.
- R5: A write (`wr`=1) drives `diow_n` low during the strobe phase. It also holds `dd_oe` high with `dd_out` equal to `wdata` from the first setup clock through the last hold clock, and low at all other times.
- R6: When the selected device's IORDY enable is set, a low `iordy` keeps the strobe asserted. The strobe ends at the first edge at which the programmed width has elapsed and `iordy` is high. When the enable is clear, `iordy` has no effect.
- R7: During a cycle, `da` equals the captured address and `cs_n` equals the inverse of the captured chip-select, both unchanged in every clock. When idle, `cs_n` is all ones and both strobes are high.
- R8: A start while `busy` is ignored. A start presented in the clock where `done` is high is accepted and begins the next cycle at once.
- R9: After reset, `busy`, `done` and `dd_oe` are low, both strobes are high, and `rdata` is zero.
- R10: The timing word, direction and device are sampled when the start is accepted. Changing them during the cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a cycle (accepted when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| dev | input | 1 | Target device 0 or 1 |
| data_cyc | input | 1 | 1 = data cycle, 0 = register cycle |
| addr | input | 3 | Register address for the bus |
| csel | input | 2 | Chip-select pattern (active high) |
| wdata | input | DW | Write data |
| t_cmd0 | input | 4*FW | Register timing, device 0 |
| t_dat0 | input | 4*FW | Data timing, device 0 |
| t_cmd1 | input | 4*FW | Register timing, device 1 |
| t_dat1 | input | 4*FW | Data timing, device 1 |
| ordy_en0 | input | 1 | IORDY wait enable, device 0 |
| ordy_en1 | input | 1 | IORDY wait enable, device 1 |
| iordy | input | 1 | Device ready (low = wait) |
| dd_in | input | DW | Data bus input |
| dd_out | output | DW | Data bus output |
| dd_oe | output | 1 | Data bus output enable |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| da | output | 3 | Bus address |
| cs_n | output | 2 | Chip-selects, active low |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DW | Captured read data |

## Verification
Two events can meet in one clock: the end-of-cycle `done` and a new start request. The bench raises `start` in the very clock where `done` is sampled high. It then judges that the second cycle begins on the next clock and keeps its own full phase lengths. The opposite case is a start that arrives mid-cycle, together with changed timing words, direction and device. For that case the bench expects the running cycle to finish with its original lengths and no extra cycle to follow.

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic          dev,
  input  logic          data_cyc,
  input  logic [2:0]    addr,
  input  logic [1:0]    csel,
  input  logic [DW-1:0] wdata,
  input  logic [4*FW-1:0] t_cmd0,
  input  logic [4*FW-1:0] t_dat0,
  input  logic [4*FW-1:0] t_cmd1,
  input  logic [4*FW-1:0] t_dat1,
  input  logic          ordy_en0,
  input  logic          ordy_en1,
  input  logic          iordy,
  input  logic [DW-1:0] dd_in,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic          dior_n,
  output logic          diow_n,
  output logic [2:0]    da,
  output logic [1:0]    cs_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int TW = 4 * FW;

  typedef enum logic [2:0] {IDLE, SETUP, STRB, HOLD, REC} phase_t;

  phase_t          ph;
  logic [TW-1:0]   tw_q;
  logic            wr_q, en_q;
  logic [2:0]      addr_q;
  logic [1:0]      cs_q;
  logic [DW-1:0]   wdata_q;
  logic [FW-1:0]   cnt, lim;
  logic [TW-1:0]   tw_sel;
  logic            last, stall;

  always_comb begin
    case ({dev, data_cyc})
      2'b00:   tw_sel = t_cmd0;
      2'b01:   tw_sel = t_dat0;
      2'b10:   tw_sel = t_cmd1;
      default: tw_sel = t_dat1;
    endcase
  end

  always_comb begin
    case (ph)
      SETUP:   lim = tw_q[FW-1:0];
      STRB:    lim = tw_q[2*FW-1:FW];
      HOLD:    lim = tw_q[3*FW-1:2*FW];
      REC:     lim = tw_q[4*FW-1:3*FW];
      default: lim = '0;
    endcase
  end

  assign last  = (cnt == lim);
  assign stall = (ph == STRB) && en_q && !iordy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      tw_q    <= '0;
      wr_q    <= 1'b0;
      en_q    <= 1'b0;
      addr_q  <= '0;
      cs_q    <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == IDLE) begin
        if (start) begin
          ph      <= SETUP;
          cnt     <= '0;
          tw_q    <= tw_sel;
          wr_q    <= wr;
          en_q    <= dev ? ordy_en1 : ordy_en0;
          addr_q  <= addr;
          cs_q    <= csel;
          wdata_q <= wdata;
        end
      end else if (last && !stall) begin
        cnt <= '0;
        case (ph)
          SETUP: ph <= STRB;
          STRB: begin
            ph <= HOLD;
            if (!wr_q) rdata <= dd_in;
          end
          HOLD:  ph <= REC;
          default: begin
            ph   <= IDLE;
            done <= 1'b1;
          end
        endcase
      end else if (!last) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy   = (ph != IDLE);
  assign dior_n = !((ph == STRB) && !wr_q);
  assign diow_n = !((ph == STRB) && wr_q);
  assign dd_oe  = wr_q && (ph == SETUP || ph == STRB || ph == HOLD);
  assign dd_out = wdata_q;
  assign da     = addr_q;
  assign cs_n   = busy ? ~cs_q : 2'b11;

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(da) && $stable(cs_n))); // R7
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(busy)); // R1
  AST_WRITE_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |-> dd_oe); // R5
  AST_IORDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n && stall) |=> !dior_n); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dior_n && diow_n && !dd_oe && cs_n == 2'b11)); // R7
endmodule

// File: tb/tb_pio_cycle_timer.sv
module tb_pio_cycle_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, dev = 1'b0, data_cyc = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] csel = '0;
  logic [15:0] wdata = '0, dd_in = '0;
  logic [31:0] t_cmd0 = '0, t_dat0 = '0, t_cmd1 = '0, t_dat1 = '0;
  logic ordy_en0 = 1'b0, ordy_en1 = 1'b0, iordy = 1'b1;
  logic [15:0] dd_out, rdata;
  logic dd_oe, dior_n, diow_n, busy, done;
  logic [2:0] da;
  logic [1:0] cs_n;

  int total = 0;
  int bad = 0;
  int seq = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_cycle_timer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .dev(dev), .data_cyc(data_cyc),
    .addr(addr), .csel(csel), .wdata(wdata),
    .t_cmd0(t_cmd0), .t_dat0(t_dat0), .t_cmd1(t_cmd1), .t_dat1(t_dat1),
    .ordy_en0(ordy_en0), .ordy_en1(ordy_en1), .iordy(iordy), .dd_in(dd_in),
    .dd_out(dd_out), .dd_oe(dd_oe), .dior_n(dior_n), .diow_n(diow_n),
    .da(da), .cs_n(cs_n), .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input int t1, input int t2, input int t4, input int te);
    return {te[7:0], t4[7:0], t2[7:0], t1[7:0]};
  endfunction

  task automatic set_all(input logic [31:0] w);
    t_cmd0 = w; t_dat0 = w; t_cmd1 = w; t_dat1 = w;
  endtask

  // Runs one cycle. Expected phase fields t1..te; rise = clocks after strobe start
  // at which iordy rises (-1: high throughout); inject = clock at which a stray
  // start with changed inputs is applied (0: none); pre = start already raised;
  // chain = raise start again in the done clock.
  task automatic run(input int t1, input int t2, input int t4, input int te,
                     input logic w, input logic d, input logic dc, input logic en,
                     input int rise, input int inject, input logic pre, input logic chain);
    int su, st, ho, re, k, first_stb, nstb, noe, nbusy, done_k, bad_addr, bad_wd;
    logic [2:0] a0;
    logic [1:0] c0;
    logic [15:0] base, wd;
    su = t1 + 1; st = t2 + 1; ho = t4 + 1; re = te + 1;
    if (en && rise >= 0 && rise + 1 > st) st = rise + 1;
    seq++;
    base = 16'(seq * 97);
    wd   = 16'(16'h5a00 + seq);
    a0 = 3'(seq); c0 = 2'(seq % 3 + 1);
    wr = w; dev = d; data_cyc = dc; addr = a0; csel = c0; wdata = wd;
    iordy = (rise >= 0) ? 1'b0 : 1'b1;
    start = 1'b1;
    first_stb = 0; nstb = 0; noe = 0; nbusy = 0; done_k = 0; bad_addr = 0; bad_wd = 0;
    for (k = 1; k <= 300 && done_k == 0; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (inject != 0 && k == inject) begin
        start = 1'b1; wr = ~w; dev = ~d; data_cyc = ~dc; set_all('0);
      end
      if (inject != 0 && k == inject + 1) start = 1'b0;
      if (busy) begin
        nbusy++;
        if (da != a0 || cs_n != ~c0) bad_addr++;
      end
      if (!dior_n || !diow_n) begin
        if (first_stb == 0) first_stb = k;
        nstb++;
        if ((w ? diow_n : dior_n) == 1'b0) ; else bad_wd++;
      end
      if (dd_oe) begin
        noe++;
        if (dd_out != wd) bad_wd++;
      end
      if (done) done_k = k;
      if (rise >= 0 && k == su + 1 + rise) iordy = 1'b1;
      dd_in = base + 16'(k);
    end
    if (chain) start = 1'b1;
    iordy = 1'b1;
    chk("R1", "strobe start clock", first_stb, su + 1);
    chk(en ? "R6" : "R2", "strobe length", nstb, st);
    chk("R2", "busy clocks", nbusy, su + st + ho + re);
    chk("R2", "done clock", done_k, su + st + ho + re + 1);
    chk("R7", "address/select changes", bad_addr, 0);
    chk("R5", "write enable clocks", noe, w ? su + st + ho : 0);
    chk(w ? "R5" : "R4", "data/strobe mismatches", bad_wd, 0);
    if (!w) chk("R4", "read capture", rdata, 32'(base + 16'(su + st)));
    if (!chain) begin
      @(negedge clk);
      chk(inject != 0 ? "R8" : "R7", "idle after done", {busy, dior_n, diow_n, cs_n}, 5'b01111);
    end
  endtask

  initial begin
    int n;
    n = 0;
    while (!finished) begin
      @(posedge clk);
      n++;
      if (n > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000", n);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset outputs", {busy, done, dd_oe, dior_n, diow_n}, 5'b00011);
    chk("R9", "reset rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5 sweep over small fields
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int e = 0; e < 3; e++) begin
            set_all(pk(a, b, c, e));
            run(a, b, c, e, 1'((a + b + c + e) % 2), 1'(a % 2), 1'(b % 2), 1'b0, -1, 0, 1'b0, 1'b0);
          end
    set_all(pk(4, 10, 3, 20));
    run(4, 10, 3, 20, 1'b0, 1'b1, 1'b1, 1'b0, -1, 0, 1'b0, 1'b0);

    // R3 word selection by device and cycle type
    t_cmd0 = pk(0, 0, 0, 0); t_dat0 = pk(0, 1, 0, 0);
    t_cmd1 = pk(0, 2, 0, 0); t_dat1 = pk(0, 3, 0, 0);
    for (int s = 0; s < 4; s++)
      run(0, s, 0, 0, 1'b0, 1'(s / 2), 1'(s % 2), 1'b0, -1, 0, 1'b0, 1'b0);

    // R6 IORDY wait enabled, disabled, and early rise
    set_all(pk(1, 1, 1, 1));
    ordy_en0 = 1'b1; ordy_en1 = 1'b0;
    run(1, 1, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 5, 0, 1'b0, 1'b0);
    run(1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
    run(1, 1, 1, 1, 1'b0, 1'b1, 1'b1, 1'b0, 50, 0, 1'b0, 1'b0);
    ordy_en0 = 1'b0; ordy_en1 = 1'b1;
    run(1, 1, 1, 1, 1'b1, 1'b1, 1'b0, 1'b1, 3, 0, 1'b0, 1'b0);
    ordy_en1 = 1'b0;

    // R8 R10 stray start and changed inputs mid-cycle
    set_all(pk(2, 2, 2, 2));
    run(2, 2, 2, 2, 1'b1, 1'b0, 1'b1, 1'b0, -1, 4, 1'b0, 1'b0);
    set_all(pk(1, 3, 0, 2));
    run(1, 3, 0, 2, 1'b0, 1'b1, 1'b0, 1'b0, -1, 2, 1'b0, 1'b0);

    // R8 start in the done clock: back-to-back cycles
    set_all(pk(1, 1, 1, 1));
    run(1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1);
    set_all(pk(0, 2, 1, 0));
    run(0, 2, 1, 0, 1'b0, 1'b1, 1'b1, 1'b0, -1, 0, 1'b1, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule